// File: doc/BRIEF.md
# Asynchronous SRAM Port Write/Read Sequencer

This block turns single-cycle requests in the system clock domain into the control sequence that an asynchronous static RAM port expects. A requester presents an address, a direction, write data and two per-request options. The sequencer then drives chip enable, read/write and output enable, the address and the write data bus through a fixed ordering of setup, strobe, hold and recovery intervals. Every interval is a whole number of clock cycles set by a parameter. A one-cycle acknowledge marks the end of each cycle, and read data is returned alongside it.

Writes come in two styles. In the R/W-terminated style, chip enable falls first and the read/write line forms the strobe. In the CE-terminated style, read/write falls first and chip enable forms the strobe, so the RAM outputs never leave high impedance. In the R/W-terminated style with output enable held low, the strobe is stretched so that the RAM's own output drivers have turned off before the controller places write data on the bus.

Top module: `sram_port_seq`

## Requirements
- R1: After reset, and whenever the sequencer is idle, mem_ce_n, mem_rw_n and mem_oe_n are high, mem_dq_oe is low, req_ready is high and ack is low.
- R2: mem_addr takes req_addr at the clock edge that accepts a request and keeps that value until the sequencer is idle again. It never changes while mem_ce_n and mem_rw_n are both low.
- R3: For a write with req_ce_style=0, mem_ce_n falls in the first cycle after acceptance. mem_rw_n falls T_AS cycles later and stays low for L cycles. mem_rw_n then rises while mem_ce_n stays low for T_DH cycles, after which both stay high for T_WR cycles.
- R4: For a write with req_ce_style=1, mem_rw_n falls in the first cycle after acceptance. mem_ce_n falls T_AS cycles later and stays low for L cycles. mem_ce_n then rises while mem_rw_n stays low for T_DH cycles, after which both stay high for T_WR cycles.
- R5: The strobe length L is max(T_WP, T_AW-T_AS, T_WZ+T_DW) for a write with req_ce_style=0 and req_oe_low=1. For every other write it is max(T_WP, T_AW-T_AS).
- R6: mem_dq_oe rises in strobe cycle L-T_DW, counting from 0. It stays high to the end of the strobe and through the following T_DH cycles, then falls. While it is high, mem_dq_out equals the accepted write data.
- R7: During a write with req_ce_style=0, mem_oe_n equals the inverse of req_oe_low from the first cycle after acceptance through the hold interval. During a write with req_ce_style=1, mem_oe_n stays high.
- R8: A read (req_write=0) holds mem_rw_n high and drops mem_ce_n and mem_oe_n together for T_ACC cycles, starting in the first cycle after acceptance. rdata takes the mem_dq_in value present in the last of those cycles, and both enables rise together.
- R9: ack is high for exactly one cycle, which is the first idle cycle after a cycle has finished. req_ready is high only while the sequencer is idle. A request presented while the sequencer is busy is ignored and has no effect on mem_addr or mem_dq_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; taken only while idle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_ce_style | input | 1 | Write style: 0 = R/W ends the strobe, 1 = CE ends the strobe |
| req_oe_low | input | 1 | Hold output enable low during an R/W-terminated write |
| req_addr | input | AW | Address of the request |
| req_wdata | input | DW | Write data of the request |
| req_ready | output | 1 | Sequencer idle, a request would be accepted |
| ack | output | 1 | One-cycle pulse when a cycle has finished |
| rdata | output | DW | Data captured by the last read |
| mem_addr | output | AW | RAM address lines |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_rw_n | output | 1 | RAM read/write, low = write |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | DW | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | DW | Data read from the RAM |

## Verification
Every pin changes at the clock edge that begins a new interval. In the k-th cycle after acceptance (k = 0 first), the expected pin levels are therefore a pure function of k, T_AS, L, T_DH and T_WR. The acknowledge is due in cycle T_AS+L+T_DH+T_WR for a write and in cycle T_ACC for a read, and rdata is valid in that same cycle. The bench samples every cycle at the falling edge, from k = 0 through the acknowledge cycle, and compares against levels it computes from k. It sweeps both write styles, both output-enable choices and all addresses of a 4-bit configuration. It keeps a conflicting request asserted throughout each busy window, and for reads it changes mem_dq_in every cycle so that a capture in any cycle other than the last one shows up.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_SETUP   = 3'd1,
      ST_STROBE  = 3'd2,
      ST_HOLD    = 3'd3,
      ST_RECOVER = 3'd4,
      ST_READ    = 3'd5
   } seq_state_e;

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   output logic [CW-1:0] count
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count <= '0;
      else if (restart) count <= '0;
      else              count <= count + 1'b1;
   end

endmodule

// File: rtl/sram_seq_plan.sv
module sram_seq_plan #(
   parameter int unsigned T_AS = 1,
   parameter int unsigned T_WP = 2,
   parameter int unsigned T_WZ = 1,
   parameter int unsigned T_DW = 1,
   parameter int unsigned T_AW = 2,
   parameter int unsigned CW   = 4
) (
   input  logic          ce_style,
   input  logic          oe_low,
   output logic [CW-1:0] strobe_len,
   output logic [CW-1:0] drive_from
);
   import sram_seq_pkg::*;

   // minimum strobe so that address-valid-to-end-of-write is met
   localparam int unsigned AW_NEED  = (T_AW > T_AS) ? (T_AW - T_AS) : 1;
   localparam int unsigned LEN_BASE = umax(T_WP, AW_NEED);
   // stretched strobe when the RAM drivers may still be on
   localparam int unsigned LEN_OE   = umax(LEN_BASE, T_WZ + T_DW);

   generate
      if (LEN_OE > LEN_BASE) begin : g_stretch
         always_comb begin
            if (!ce_style && oe_low) strobe_len = CW'(LEN_OE);
            else                     strobe_len = CW'(LEN_BASE);
         end
      end else begin : g_flat
         logic unused_opts;
         assign unused_opts = ce_style ^ oe_low;
         assign strobe_len  = CW'(LEN_BASE);
      end
   endgenerate

   // data goes on the bus T_DW cycles before the strobe ends
   assign drive_from = strobe_len - CW'(T_DW);

endmodule

// File: rtl/sram_seq_pins.sv
module sram_seq_pins #(
   parameter int unsigned CW = 4
) (
   input  sram_seq_pkg::seq_state_e state,
   input  logic                     ce_style,
   input  logic                     oe_low,
   input  logic [CW-1:0]            count,
   input  logic [CW-1:0]            drive_from,
   output logic                     ce_n,
   output logic                     rw_n,
   output logic                     oe_n,
   output logic                     dq_oe
);
   import sram_seq_pkg::*;

   logic in_setup, in_strobe, in_hold, in_read, wr_busy;

   assign in_setup  = (state == ST_SETUP);
   assign in_strobe = (state == ST_STROBE);
   assign in_hold   = (state == ST_HOLD);
   assign in_read   = (state == ST_READ);
   assign wr_busy   = in_setup | in_strobe | in_hold;

   always_comb begin
      if (ce_style) begin
         // read/write opens first, chip enable is the strobe
         ce_n = ~(in_strobe | in_read);
         rw_n = ~wr_busy;
         oe_n = ~in_read;
      end else begin
         // chip enable opens first, read/write is the strobe
         ce_n = ~(wr_busy | in_read);
         rw_n = ~in_strobe;
         oe_n = ~((wr_busy & oe_low) | in_read);
      end
   end

   assign dq_oe = (in_strobe && (count >= drive_from)) || in_hold;

endmodule

// File: rtl/sram_port_seq.sv
module sram_port_seq #(
   parameter int unsigned AW    = 11,
   parameter int unsigned DW    = 8,
   parameter int unsigned T_AS  = 1,
   parameter int unsigned T_WP  = 2,
   parameter int unsigned T_WZ  = 1,
   parameter int unsigned T_DW  = 1,
   parameter int unsigned T_DH  = 1,
   parameter int unsigned T_WR  = 1,
   parameter int unsigned T_AW  = 2,
   parameter int unsigned T_ACC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic          req_ce_style,
   input  logic          req_oe_low,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          req_ready,
   output logic          ack,
   output logic [DW-1:0] rdata,
   output logic [AW-1:0] mem_addr,
   output logic          mem_ce_n,
   output logic          mem_rw_n,
   output logic          mem_oe_n,
   output logic [DW-1:0] mem_dq_out,
   output logic          mem_dq_oe,
   input  logic [DW-1:0] mem_dq_in
);
   import sram_seq_pkg::*;

   localparam int unsigned TMAX = umax(umax(umax(T_AS, T_WP), umax(T_WZ + T_DW, T_AW)),
                                       umax(umax(T_DH, T_WR), T_ACC));
   localparam int unsigned CW   = $clog2(TMAX + 1) + 1;

   // elaboration-time parameter checks
   generate
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("sram_port_seq: AW and DW must be at least 1");
      end
      if (T_AS < 1 || T_WP < 1 || T_WZ < 1 || T_DW < 1 ||
          T_DH < 1 || T_WR < 1 || T_AW < 1 || T_ACC < 1) begin : g_bad_timing
         $error("sram_port_seq: every interval must be at least one cycle");
      end
      if (T_DW > T_WP) begin : g_bad_dw
         $error("sram_port_seq: T_DW may not exceed T_WP");
      end
   endgenerate

   seq_state_e    state_q, state_d;
   logic          style_q, oe_low_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q, rdata_q;
   logic          ack_q;
   logic [CW-1:0] count, stage_len, strobe_len, drive_from;
   logic          stage_last, accept, restart;

   sram_seq_plan #(
      .T_AS(T_AS), .T_WP(T_WP), .T_WZ(T_WZ), .T_DW(T_DW), .T_AW(T_AW), .CW(CW)
   ) i_plan (
      .ce_style  (style_q),
      .oe_low    (oe_low_q),
      .strobe_len(strobe_len),
      .drive_from(drive_from)
   );

   always_comb begin
      unique case (state_q)
         ST_SETUP:   stage_len = CW'(T_AS);
         ST_STROBE:  stage_len = strobe_len;
         ST_HOLD:    stage_len = CW'(T_DH);
         ST_RECOVER: stage_len = CW'(T_WR);
         ST_READ:    stage_len = CW'(T_ACC);
         default:    stage_len = CW'(1);
      endcase
   end

   assign stage_last = (count == stage_len - 1'b1);
   assign accept     = (state_q == ST_IDLE) && req_valid;
   assign restart    = (state_q == ST_IDLE) || stage_last;

   sram_seq_timer #(.CW(CW)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(restart),
      .count  (count)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (accept) state_d = req_write ? ST_SETUP : ST_READ;
         ST_SETUP:   if (stage_last) state_d = ST_STROBE;
         ST_STROBE:  if (stage_last) state_d = ST_HOLD;
         ST_HOLD:    if (stage_last) state_d = ST_RECOVER;
         ST_RECOVER: if (stage_last) state_d = ST_IDLE;
         ST_READ:    if (stage_last) state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         style_q  <= 1'b0;
         oe_low_q <= 1'b0;
         addr_q   <= '0;
         wdata_q  <= '0;
         rdata_q  <= '0;
         ack_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         ack_q   <= ((state_q == ST_RECOVER) || (state_q == ST_READ)) && stage_last;
         if (accept) begin
            style_q  <= req_ce_style;
            oe_low_q <= req_oe_low;
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
         end
         if ((state_q == ST_READ) && stage_last) rdata_q <= mem_dq_in;
      end
   end

   sram_seq_pins #(.CW(CW)) i_pins (
      .state     (state_q),
      .ce_style  (style_q),
      .oe_low    (oe_low_q),
      .count     (count),
      .drive_from(drive_from),
      .ce_n      (mem_ce_n),
      .rw_n      (mem_rw_n),
      .oe_n      (mem_oe_n),
      .dq_oe     (mem_dq_oe)
   );

   assign req_ready  = (state_q == ST_IDLE);
   assign ack        = ack_q;
   assign rdata      = rdata_q;
   assign mem_addr   = addr_q;
   assign mem_dq_out = wdata_q;

endmodule

// File: rtl/sram_port_seq_chk.sv
module sram_port_seq_chk #(
   parameter int unsigned AW   = 11,
   parameter int unsigned T_WP = 2,
   parameter int unsigned T_WZ = 1,
   parameter int unsigned T_DW = 1,
   parameter int unsigned T_DH = 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready,
   input logic          ack,
   input logic [AW-1:0] mem_addr,
   input logic          mem_ce_n,
   input logic          mem_rw_n,
   input logic          mem_oe_n,
   input logic          mem_dq_oe
);

   logic        overlap;
   int unsigned ovl_cnt, drv_cnt, rwlow_cnt, hold_cnt;

   assign overlap = !mem_ce_n && !mem_rw_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovl_cnt   <= 0;
         drv_cnt   <= 0;
         rwlow_cnt <= 0;
         hold_cnt  <= 0;
      end else begin
         ovl_cnt   <= overlap ? ovl_cnt + 1 : 0;
         drv_cnt   <= !overlap ? 0 : (mem_dq_oe ? drv_cnt + 1 : drv_cnt);
         rwlow_cnt <= !mem_rw_n ? rwlow_cnt + 1 : 0;
         hold_cnt  <= overlap ? 0 : (mem_dq_oe ? hold_cnt + 1 : 0);
      end
   end

   // R1: idle pins
   p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_rw_n && mem_oe_n && !mem_dq_oe));

   // R2: address frozen while busy
   p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> $stable(mem_addr));

   // R5: write overlap lasts at least the minimum pulse
   p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(overlap) |-> (ovl_cnt >= T_WP));

   // R5: data only driven once the RAM drivers are off
   p_no_fight_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_dq_oe) && !mem_oe_n) |-> (rwlow_cnt >= T_WZ));

   // R6: data setup before the strobe ends
   p_data_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(overlap) |-> (drv_cnt >= T_DW));

   // R6: data hold after the strobe ends
   p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_dq_oe) |-> (hold_cnt >= T_DH));

   // R8: output enable low with R/W high implies a selected chip
   p_read_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n && mem_rw_n) |-> !mem_ce_n);

   // R9: acknowledge is a single idle-cycle pulse
   p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> req_ready);
   p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

endmodule

bind sram_port_seq sram_port_seq_chk #(
   .AW(AW), .T_WP(T_WP), .T_WZ(T_WZ), .T_DW(T_DW), .T_DH(T_DH)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_ready(req_ready),
   .ack      (ack),
   .mem_addr (mem_addr),
   .mem_ce_n (mem_ce_n),
   .mem_rw_n (mem_rw_n),
   .mem_oe_n (mem_oe_n),
   .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_port_seq.sv
`timescale 1ns/1ps
module test_sram_port_seq;

   localparam int AW    = 4;
   localparam int DW    = 8;
   localparam int T_AS  = 2;
   localparam int T_WP  = 3;
   localparam int T_WZ  = 2;
   localparam int T_DW  = 2;
   localparam int T_DH  = 1;
   localparam int T_WR  = 2;
   localparam int T_AW  = 4;
   localparam int T_ACC = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0, req_ce_style = 1'b0, req_oe_low = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, ack;
   logic [DW-1:0] rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_ce_n, mem_rw_n, mem_oe_n, mem_dq_oe;
   logic [DW-1:0] mem_dq_out;
   logic [DW-1:0] mem_dq_in = '0;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #5 clk = ~clk;

   sram_port_seq #(
      .AW(AW), .DW(DW), .T_AS(T_AS), .T_WP(T_WP), .T_WZ(T_WZ), .T_DW(T_DW),
      .T_DH(T_DH), .T_WR(T_WR), .T_AW(T_AW), .T_ACC(T_ACC)
   ) i_sram_port_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_ce_style(req_ce_style), .req_oe_low(req_oe_low), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready), .ack(ack), .rdata(rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_rw_n(mem_rw_n),
      .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // pins packed as {ce_n, rw_n, oe_n, dq_oe, ack, ready}
   function automatic logic [5:0] pins();
      return {mem_ce_n, mem_rw_n, mem_oe_n, mem_dq_oe, ack, req_ready};
   endfunction

   task automatic do_write(input bit ce_style, input bit oe_low,
                           input logic [AW-1:0] a, input logic [DW-1:0] d);
      int len, total;
      // R5: strobe length
      len = imax(T_WP, T_AW - T_AS);
      if (!ce_style && oe_low) len = imax(len, T_WZ + T_DW);
      total = T_AS + len + T_DH + T_WR;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_ce_style = ce_style;
      req_oe_low = oe_low; req_addr = a; req_wdata = d;
      @(negedge clk);
      // R9: conflicting request kept up while busy
      req_addr = ~a; req_wdata = ~d; req_write = 1'b0; req_ce_style = ~ce_style;
      for (int k = 0; k <= total; k++) begin
         bit setup, strobe, hold, busy;
         logic ce_e, rw_e, oe_e, dq_e;
         setup  = (k < T_AS);
         strobe = (k >= T_AS) && (k < T_AS + len);
         hold   = (k >= T_AS + len) && (k < T_AS + len + T_DH);
         busy   = setup | strobe | hold;
         dq_e   = (strobe && (k - T_AS >= len - T_DW)) || hold;
         if (ce_style) begin
            ce_e = ~strobe; rw_e = ~busy; oe_e = 1'b1;
         end else begin
            ce_e = ~busy; rw_e = ~strobe; oe_e = ~(busy & oe_low);
         end
         check(pins() == {ce_e, rw_e, oe_e, dq_e, (k == total), (k == total)},
               ce_style ? "R4/R5/R6/R9 CE-style pins" : "R3/R5/R6/R7/R9 RW-style pins",
               32'(pins()), 32'({ce_e, rw_e, oe_e, dq_e, (k == total), (k == total)}));
         check(mem_addr == a, "R2 address held", 32'(mem_addr), 32'(a));
         if (dq_e) check(mem_dq_out == d, "R6 write data", 32'(mem_dq_out), 32'(d));
         if (k == total - 1) req_valid = 1'b0;
         if (k < total) @(negedge clk);
      end
   endtask

   task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] base);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_ce_style = 1'b0; req_oe_low = 1'b0;
      @(negedge clk);
      req_addr = ~a; req_write = 1'b1;
      for (int k = 0; k <= T_ACC; k++) begin
         bit rd;
         rd = (k < T_ACC);
         mem_dq_in = base ^ DW'(k);
         check(pins() == {~rd, 1'b1, ~rd, 1'b0, ~rd, ~rd}, "R8/R9 read pins",
               32'(pins()), 32'({~rd, 1'b1, ~rd, 1'b0, ~rd, ~rd}));
         check(mem_addr == a, "R2 read address", 32'(mem_addr), 32'(a));
         if (k == T_ACC)
            check(rdata == (base ^ DW'(T_ACC - 1)), "R8 read capture", 32'(rdata),
                  32'(base ^ DW'(T_ACC - 1)));
         if (k == T_ACC - 1) req_valid = 1'b0;
         if (k < T_ACC) @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(pins() == 6'b111001, "R1 reset pins", 32'(pins()), 32'(6'b111001));
      rst_n = 1'b1;
      @(negedge clk);
      check(pins() == 6'b111001, "R1 idle pins after reset", 32'(pins()), 32'(6'b111001));
      for (int s = 0; s < 2; s++)
         for (int o = 0; o < 2; o++)
            for (int a = 0; a < (1 << AW); a++)
               do_write(s[0], o[0], AW'(a), DW'(a * 37 + s * 101 + o * 53 + 1));
      for (int a = 0; a < (1 << AW); a++)
         do_read(AW'(a), DW'(a * 29 + 7));
      @(negedge clk);
      check(pins() == 6'b111001, "R1 idle at end", 32'(pins()), 32'(6'b111001));
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

endmodule